// File: doc/BRIEF.md
# Pause-Width Reader Bit Modulator

This block sends one reader-to-card frame over an amplitude-keyed carrier. Every bit opens with a short carrier-off pause of fixed length. The value of the bit is carried by how long the whole bit lasts: a long period stands for a 1 and a short period for a 0. Before each bit leaves, it is XORed with one bit from an external keystream generator, and the block advances that generator once per bit. A last pause after the final bit marks the end of the frame.

All timing runs against an external free-running tick counter, at 1.5 ticks per microsecond. On a start strobe the block takes a base timestamp, which is the end of the previous frame on air. It holds off for a fixed gap after that stamp. From then on it builds every deadline by adding onto the previous deadline, never onto the current time, so the frame stays locked to the base stamp no matter when the start strobe arrives. When the end pause finishes, the block pulses done and presents the final deadline as the new shared timestamp, ready to seed the next frame or receive window.

Top module: `pause_width_tx`

## Requirements
- R1: During and after reset, and while idle, carrier_off_o, ks_adv_o and done_o are all 0.
- R2: After start_i, the first carrier-off pause begins at tick base_ts_i + 330.
- R3: Each transmitted bit begins with a carrier-off pause of exactly 30 ticks.
- R4: A bit sent at level 1 lasts 150 ticks in total (30 paused, 120 carrier on). A bit sent at level 0 lasts 90 ticks (30 paused, 60 on).
- R5: Bits go out least significant first, frame_i[0] first. The level sent is frame_i[i] XOR ks_bit_i, sampled in the cycle the bit's pause starts. ks_adv_o pulses for one cycle exactly as each data bit's pause starts, so there is one pulse per data bit.
- R6: After the last bit, a 30-tick end pause is sent and the carrier is then restored. done_o pulses for one cycle in that same cycle, and end_ts_o then equals the tick at which the end pause ended.
- R7: Every carrier transition falls on the tick base_ts_i + 330 plus the sum of the preceding durations. It does not depend on when start_i came, as long as the first deadline has not passed. Feeding end_ts_o back as the next base chains frames without drift.
- R8: With len_i = 0, only the end pause is sent, from base+330 to base+360, with no ks_adv_o pulse.
- R9: A len_i greater than 32 is treated as 32.
- R10: start_i while a frame is in progress is ignored. The frame's timing, levels and advance count are unchanged.
- R11: Deadlines compare modulo 2^32, so a frame that crosses the tick counter's wrap keeps exact timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a frame (taken only while idle) |
| frame_i | input | 32 | Frame data, bit 0 sent first |
| len_i | input | 6 | Number of bits to send, 0 to 32 (larger values are clamped) |
| base_ts_i | input | 32 | Shared timestamp of the previous frame end |
| now_ts_i | input | 32 | Free-running tick counter |
| ks_bit_i | input | 1 | Current keystream bit |
| ks_adv_o | output | 1 | One-cycle pulse to advance the keystream |
| carrier_off_o | output | 1 | 1 while the carrier is paused |
| done_o | output | 1 | One-cycle pulse when the end pause finishes |
| end_ts_o | output | 32 | Accumulated deadline, the new shared timestamp after done |

## Verification
The bench keeps its own keystream copy and predicts the exact tick of every carrier edge. It runs frames of length 0, 1, 6, 7, 32 and an over-long 40, a frame whose base is already 200 ticks in the past, a frame chained from the previous end stamp, and a frame that crosses the 32-bit wrap of the tick counter. A design that restarted deadlines from the current time would move every edge of the late-base and chained frames. A plain magnitude compare would stall or fire early at the wrap. Sampling the keystream at the wrong moment, or advancing it on the end pause, would change the mark lengths or the advance count. A stray start pulse in the middle of a frame checks that a busy block does not reload its data or its deadline.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_PAUSE = 3'd2,
        ST_MARK  = 3'd3,
        ST_TAIL  = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic carrier_off;
        logic ks_adv;
        logic done;
    } line_out_t;

    // carrier-on time that follows the pause, from the total bit period
    function automatic int unsigned carrier_span(input logic lvl,
                                                 input int unsigned one_total,
                                                 input int unsigned zero_total,
                                                 input int unsigned pause);
        return (lvl ? one_total : zero_total) - pause;
    endfunction

endpackage

// File: rtl/pw_deadline.sv
module pw_deadline #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [TS_W-1:0] load_val,
    input  logic [TS_W-1:0] inc,
    input  logic [TS_W-1:0] now_i,
    output logic [TS_W-1:0] stamp_o,
    output logic            reached_o
);
    logic [TS_W-1:0] stamp;
    logic [TS_W-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp <= '0;
        end else if (load) begin
            stamp <= load_val;
        end else if (step) begin
            stamp <= stamp + inc;
        end
    end

    // modulo compare: reached once now is not behind the stamp
    always_comb begin
        diff      = now_i - stamp;
        reached_o = ~diff[TS_W-1];
    end

    assign stamp_o = stamp;

endmodule

// File: rtl/pw_bitsrc.sv
module pw_bitsrc #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                take,
    input  logic [MAX_BITS-1:0] frame_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic                bit_o,
    output logic                empty_o
);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BITS);

    logic [MAX_BITS-1:0] shreg;
    logic [LEN_W-1:0]    left;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            left  <= '0;
        end else if (load) begin
            shreg <= frame_i;
            left  <= (len_i > LEN_CAP) ? LEN_CAP : len_i;
        end else if (take && (left != '0)) begin
            shreg <= shreg >> 1;
            left  <= left - 1'b1;
        end
    end

    assign bit_o   = shreg[0];
    assign empty_o = (left == '0);

    assert_left_cap_R9: assert property (@(posedge clk) disable iff (rst)
        left <= LEN_CAP);

endmodule

// File: rtl/pause_width_tx.sv
module pause_width_tx
    import pwtx_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int MAX_BITS    = 32,
    parameter int LEN_W       = $clog2(MAX_BITS + 1),
    parameter int GAP_TICKS   = 330,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] frame_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [TS_W-1:0]     base_ts_i,
    input  logic [TS_W-1:0]     now_ts_i,
    input  logic                ks_bit_i,
    output logic                ks_adv_o,
    output logic                carrier_off_o,
    output logic                done_o,
    output logic [TS_W-1:0]     end_ts_o
);
    localparam logic [TS_W-1:0] GAP_INC   = TS_W'(GAP_TICKS);
    localparam logic [TS_W-1:0] PAUSE_INC = TS_W'(PAUSE_TICKS);

    tx_state_e       st, st_n;
    line_out_t       line_q, line_n;
    logic            lvl_q, lvl_n;

    logic            dl_load, dl_step, dl_reached;
    logic [TS_W-1:0] dl_inc;
    logic            bs_load, bs_take, bs_bit, bs_empty;

    pw_deadline #(.TS_W(TS_W)) u_deadline (
        .clk       (clk),
        .rst       (rst),
        .load      (dl_load),
        .step      (dl_step),
        .load_val  (base_ts_i + GAP_INC),
        .inc       (dl_inc),
        .now_i     (now_ts_i),
        .stamp_o   (end_ts_o),
        .reached_o (dl_reached)
    );

    pw_bitsrc #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_bitsrc (
        .clk     (clk),
        .rst     (rst),
        .load    (bs_load),
        .take    (bs_take),
        .frame_i (frame_i),
        .len_i   (len_i),
        .bit_o   (bs_bit),
        .empty_o (bs_empty)
    );

    always_comb begin
        st_n               = st;
        line_n             = line_q;
        line_n.ks_adv      = 1'b0;
        line_n.done        = 1'b0;
        lvl_n              = lvl_q;
        dl_load            = 1'b0;
        dl_step            = 1'b0;
        dl_inc             = PAUSE_INC;
        bs_load            = 1'b0;
        bs_take            = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_i) begin
                    dl_load = 1'b1;
                    bs_load = 1'b1;
                    st_n    = ST_GAP;
                end
            end
            ST_GAP, ST_MARK: begin
                if (dl_reached) begin
                    dl_step            = 1'b1;
                    dl_inc             = PAUSE_INC;
                    line_n.carrier_off = 1'b1;
                    if (bs_empty) begin
                        st_n = ST_TAIL;
                    end else begin
                        bs_take       = 1'b1;
                        lvl_n         = bs_bit ^ ks_bit_i;
                        line_n.ks_adv = 1'b1;
                        st_n          = ST_PAUSE;
                    end
                end
            end
            ST_PAUSE: begin
                if (dl_reached) begin
                    dl_step            = 1'b1;
                    dl_inc             = TS_W'(carrier_span(lvl_q, ONE_TICKS,
                                                            ZERO_TICKS, PAUSE_TICKS));
                    line_n.carrier_off = 1'b0;
                    st_n               = ST_MARK;
                end
            end
            ST_TAIL: begin
                if (dl_reached) begin
                    line_n.carrier_off = 1'b0;
                    line_n.done        = 1'b1;
                    st_n               = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            line_q <= '0;
            lvl_q  <= 1'b0;
        end else begin
            st     <= st_n;
            line_q <= line_n;
            lvl_q  <= lvl_n;
        end
    end

    assign carrier_off_o = line_q.carrier_off;
    assign ks_adv_o      = line_q.ks_adv;
    assign done_o        = line_q.done;

    assert_adv_at_pause_R5: assert property (@(posedge clk) disable iff (rst)
        ks_adv_o |-> (carrier_off_o && !$past(carrier_off_o)));

    assert_done_on_restore_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!carrier_off_o && $past(carrier_off_o)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_edge_on_deadline_R7: assert property (@(posedge clk) disable iff (rst)
        (carrier_off_o != $past(carrier_off_o)) |-> $past(dl_reached));

endmodule

// File: tb/pause_width_tx_tb.sv
module pause_width_tx_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] frame;
    logic [5:0]  len;
    logic [31:0] base;
    logic [31:0] ticks;
    logic        tick_load;
    logic [31:0] tick_val;
    logic [6:0]  ks_state;
    logic        ks_adv, carrier_off, done;
    logic [31:0] end_ts;

    always #5 clk = ~clk;

    pause_width_tx u_dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .frame_i       (frame),
        .len_i         (len),
        .base_ts_i     (base),
        .now_ts_i      (ticks),
        .ks_bit_i      (ks_state[0]),
        .ks_adv_o      (ks_adv),
        .carrier_off_o (carrier_off),
        .done_o        (done),
        .end_ts_o      (end_ts)
    );

    function automatic logic [6:0] ks_step(input logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    always @(posedge clk) begin
        if (tick_load) ticks <= tick_val;
        else           ticks <= ticks + 32'd1;
        if (rst)         ks_state <= 7'h5A;
        else if (ks_adv) ks_state <= ks_step(ks_state);
    end

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] exp_t_q[$];
    logic        exp_l_q[$];
    string       exp_g_q[$];
    logic [31:0] exp_end_q[$];
    logic        prev_co;
    bit          got_done;
    int          adv_cnt;
    logic [6:0]  ks_shadow;
    logic [31:0] last_end;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            prev_co = 1'b0;
        end else begin
            if (carrier_off !== prev_co) begin
                if (exp_t_q.size() == 0) begin
                    check(1'b0, "R10 unexpected edge", ticks - 32'd1, 32'd0);
                end else begin
                    automatic logic [31:0] et = exp_t_q.pop_front();
                    automatic logic        el = exp_l_q.pop_front();
                    automatic string       eg = exp_g_q.pop_front();
                    check((ticks - 32'd1) == et && carrier_off == el,
                          {eg, " edge tick"}, ticks - 32'd1, et);
                end
                prev_co = carrier_off;
            end
            if (ks_adv) adv_cnt++;
            if (done) begin
                if (exp_end_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", ticks, 32'd0);
                end else begin
                    automatic logic [31:0] ee = exp_end_q.pop_front();
                    check((ticks - 32'd1) == ee, "R6 done tick", ticks - 32'd1, ee);
                    check(end_ts == ee, "R6 end_ts", end_ts, ee);
                end
                got_done = 1'b1;
            end
        end
    end

    task automatic push(input logic [31:0] t, input logic l, input string g);
        exp_t_q.push_back(t);
        exp_l_q.push_back(l);
        exp_g_q.push_back(g);
    endtask

    task automatic run_frame(input logic [31:0] data, input int n_req,
                             input logic [31:0] b, input bit poke, input string tag);
        automatic int          n = (n_req > 32) ? 32 : n_req;
        automatic logic [31:0] t = b + 32'd330;
        push(t, 1'b1, {tag, " R2"});
        for (int i = 0; i < n; i++) begin
            automatic logic lv = data[i] ^ ks_shadow[0];
            ks_shadow = ks_step(ks_shadow);
            t = t + 32'd30;
            push(t, 1'b0, {tag, " R3"});
            t = t + (lv ? 32'd120 : 32'd60);
            push(t, 1'b1, {tag, " R4 R5"});
        end
        t = t + 32'd30;
        push(t, 1'b0, {tag, " R6"});
        exp_end_q.push_back(t);
        got_done = 1'b0;
        adv_cnt  = 0;
        start = 1'b1; frame = data; len = 6'(n_req); base = b;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (200) @(negedge clk);
            start = 1'b1; frame = ~data; len = 6'd5; base = ticks;
            @(negedge clk);
            start = 1'b0;
        end
        while (!got_done) @(negedge clk);
        check(adv_cnt == n, {tag, " R5 advance count"}, 32'(adv_cnt), 32'(n));
        check(exp_t_q.size() == 0, {tag, " R6 missing edges"}, 32'(exp_t_q.size()), 0);
        repeat (3) @(negedge clk);
        check(carrier_off == 1'b0 && done == 1'b0 && ks_adv == 1'b0,
              {tag, " R1 idle after frame"}, {29'd0, carrier_off, done, ks_adv}, 0);
        last_end = t;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; frame = '0; len = '0; base = '0;
        tick_load = 1'b1; tick_val = 32'd1000;
        ks_shadow = 7'h5A;
        repeat (3) @(negedge clk);
        tick_load = 1'b0;
        check(carrier_off == 0 && done == 0 && ks_adv == 0, "R1 in reset",
              {29'd0, carrier_off, done, ks_adv}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(carrier_off == 0 && done == 0 && ks_adv == 0, "R1 idle",
              {29'd0, carrier_off, done, ks_adv}, 0);

        run_frame(32'h0000_0055, 7,  ticks, 1'b0, "f7");
        run_frame(32'h0000_0019, 6,  ticks, 1'b0, "f6");
        run_frame(32'hA5C3_0F96, 32, ticks, 1'b0, "f32");
        run_frame(32'hFFFF_FFFF, 0,  ticks, 1'b0, "R8 len0");
        run_frame(32'h0000_0001, 1,  ticks, 1'b0, "len1");
        run_frame(32'h1234_5678, 40, ticks, 1'b0, "R9 len40");
        run_frame(32'h0000_0ACE, 12, last_end, 1'b0, "R7 chained");
        run_frame(32'h0000_00F0, 8,  ticks - 32'd200, 1'b0, "R7 late base");
        run_frame(32'h0000_3C3C, 14, ticks, 1'b1, "R10 poke");

        @(negedge clk);
        tick_load = 1'b1; tick_val = 32'hFFFF_FE00;
        @(negedge clk);
        tick_load = 1'b0;
        @(negedge clk);
        run_frame(32'h0000_00B7, 8, ticks, 1'b0, "R11 wrap");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule